// File: doc/BRIEF.md
# Serially programmed quad delay line

This block models, in system clock cycles, a four-channel programmable delay line. Each channel copies its one-bit input to its output, without inversion, after a latency of `T0_CYC + code * STEP_CYC` clock cycles. `code` is that channel's 4-bit delay setting. Rising and falling edges are both shifted by the same amount. A channel can also be switched off, and its output then stays low.

The settings arrive over a three-wire serial port: a serial clock, a serial data line and a latch strobe. All three are brought into the system clock domain through two-flop synchronizers. Each detected rising edge of the serial clock shifts one bit into a 20-bit staging register. A rising edge of the strobe copies the staged word into the active settings. The serial output carries the bit that leaves the far end of the staging register, so several blocks can be chained.

Top module: `sdl_quad`

## Requirements
- R1: While reset is held, and after it is released with no strobe yet seen, every output and the serial output are low.
- R2: For an enabled channel with active code c, the output after clock edge k equals that channel's input as sampled at edge k − (T0_CYC + c·STEP_CYC).
- R3: A pulse on an enabled channel keeps its width and polarity at the output, because the rising and falling edges are delayed alike.
- R4: The staging word is 20 bits, shifted in most significant bit first. Bits 19..16 hold the code of channel 0, 15..12 channel 1, 11..8 channel 2 and 7..4 channel 3. Bits 3..0 are the enables of channels 0..3, in that order, with bit 3 for channel 0.
- R5: The serial output is bit 19 of the staging register. It changes only on a shift, so a word shifted in reappears there, first bit first, over the next 20 shifts.
- R6: Shifting without a strobe edge leaves the active codes, enables and delays unchanged.
- R7: A disabled channel drives its output low whatever its input does.
- R8: When a serial-clock rising edge and a strobe rising edge are detected in the same cycle, the latch takes the staging word as it was before that cycle's shift.
- R9: The four channels run with independent codes and enables at the same time.
- R10: Code 0 gives the minimum latency T0_CYC and code 15 gives the maximum T0_CYC + 15·STEP_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 4 | Channel inputs, bit n is channel n |
| dout | output | 4 | Delayed channel outputs |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in, asynchronous |
| ser_latch | input | 1 | Latch strobe, asynchronous, acts on rising edge |
| ser_dout | output | 1 | Serial data out for chaining |

## Verification
A shift and a latch can be detected in the same system clock cycle. The bench provokes this by raising the serial clock and the strobe pins on the same falling clock edge while the twentieth bit of a new word is presented. Both signals pass through identical synchronizers, so their edges meet in one cycle. The bench expects the latched setting to be the previous word's last bit followed by the first nineteen bits of the new word. It then judges the result from the delay and enable pattern visible on all four outputs.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int NCH    = 4;
  localparam int CODE_W = 4;
  localparam int WORD_W = NCH * CODE_W + NCH;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0]           code_t;
  typedef logic [NCH-1:0][CODE_W-1:0]  code_vec_t;
  typedef logic [WORD_W-1:0]           word_t;

  // Latency in cycles for one channel.
  function automatic int tap_depth(input int t0, input int step, input int code);
    return t0 + code * step;
  endfunction

  // Code field of channel ch; channel 0 sits at the top of the word.
  function automatic code_t field_code(input word_t w, input int ch);
    return w[WORD_W-1-ch*CODE_W -: CODE_W];
  endfunction

  // Enable bit of channel ch; the enables fill the bottom NCH bits.
  function automatic logic field_en(input word_t w, input int ch);
    return w[NCH-1-ch];
  endfunction
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdl_serial_port.sv
module sdl_serial_port import sdl_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_s,
  input  logic           sdi_s,
  input  logic           latch_s,
  output logic           shift_ev,
  output logic           latch_ev,
  output word_t          shreg,
  output code_vec_t      codes,
  output logic [NCH-1:0] en_act,
  output logic           sdo
);
  logic sclk_q, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      latch_q <= latch_s;
    end
  end

  assign shift_ev = sclk_s & ~sclk_q;
  assign latch_ev = latch_s & ~latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (shift_ev) shreg <= {shreg[WORD_W-2:0], sdi_s};
  end

  // Reads shreg before this cycle's shift lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes  <= '0;
      en_act <= '0;
    end else if (latch_ev) begin
      for (int n = 0; n < NCH; n++) begin
        codes[n]  <= field_code(shreg, n);
        en_act[n] <= field_en(shreg, n);
      end
    end
  end

  assign sdo = shreg[WORD_W-1];
endmodule

// File: rtl/sdl_tap_line.sv
module sdl_tap_line import sdl_pkg::*; #(
  parameter int T0_CYC   = 3,
  parameter int STEP_CYC = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  din,
  input  code_t code,
  input  logic  en,
  output logic  dout
);
  localparam int DEPTH = T0_CYC + MAX_CODE * STEP_CYC;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] pipe;
  logic [IDX_W-1:0] sel;

  // pipe[j] holds the input sampled j edges before the latest one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], din};
  end

  // One extra register on the output, so the tap sits one stage short.
  assign sel = IDX_W'(tap_depth(T0_CYC, STEP_CYC, int'(code)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= en ? pipe[sel] : 1'b0;
  end
endmodule

// File: rtl/sdl_quad.sv
module sdl_quad import sdl_pkg::*; #(
  parameter int T0_CYC      = 3,
  parameter int STEP_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] dout,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_latch,
  output logic           ser_dout
);
  logic [2:0]     pins_s;
  logic           shift_ev, latch_ev;
  word_t          shreg;
  code_vec_t      codes;
  logic [NCH-1:0] en_act;

  sdl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_latch, ser_din, ser_clk}),
    .q     (pins_s)
  );

  sdl_serial_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[0]),
    .sdi_s    (pins_s[1]),
    .latch_s  (pins_s[2]),
    .shift_ev (shift_ev),
    .latch_ev (latch_ev),
    .shreg    (shreg),
    .codes    (codes),
    .en_act   (en_act),
    .sdo      (ser_dout)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sdl_tap_line #(.T0_CYC(T0_CYC), .STEP_CYC(STEP_CYC)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din[g]),
      .code  (codes[g]),
      .en    (en_act[g]),
      .dout  (dout[g])
    );
  end
endmodule

// File: rtl/sdl_quad_chk.sv
module sdl_quad_chk import sdl_pkg::*; (
  input logic           clk,
  input logic           rst_n,
  input logic           shift_ev,
  input logic           latch_ev,
  input word_t          shreg,
  input code_vec_t      codes,
  input logic [NCH-1:0] en_act,
  input logic [NCH-1:0] dout,
  input logic           ser_dout
);
  // R6
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_ev |=> ($stable(codes) && $stable(en_act)));

  // R5
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_ev |=> $stable(ser_dout));

  // R5
  sdo_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (ser_dout == $past(shreg[WORD_W-2])));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_act[g] |=> !dout[g]);

    // R4 R8
    latch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_ev |=> (codes[g] == $past(shreg[WORD_W-1-g*CODE_W -: CODE_W])));

    // R4 R8
    latch_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_ev |=> (en_act[g] == $past(shreg[NCH-1-g])));
  end
endmodule

bind sdl_quad sdl_quad_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shift_ev (shift_ev),
  .latch_ev (latch_ev),
  .shreg    (shreg),
  .codes    (codes),
  .en_act   (en_act),
  .dout     (dout),
  .ser_dout (ser_dout)
);

// File: tb/sdl_quad_tb.sv
`timescale 1ns/1ps
module sdl_quad_tb;
  localparam int T0 = 3, TI = 2, NCH = 4, WW = 20, HL = 64;
  localparam int MAXD = T0 + 15 * TI;

  typedef struct packed {
    logic [19:0] word;
    logic [5:0]  d0, d1, d2, d3;   // expected latency, 0 = output held low
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{20'h0F59F, 6'd3,  6'd33, 6'd13, 6'd21},
    '{20'h7777A, 6'd17, 6'd0,  6'd17, 6'd0 },
    '{20'hF01E7, 6'd0,  6'd3,  6'd5,  6'd31},
    '{20'h3C82F, 6'd9,  6'd27, 6'd19, 6'd7 },
    '{20'h00009, 6'd3,  6'd0,  6'd0,  6'd3 }
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] din = 0;
  logic [3:0] dout;
  logic sclk = 0, sdi = 0, slat = 0;
  logic sdo;

  always #2.5 clk = ~clk;

  sdl_quad #(.T0_CYC(T0), .STEP_CYC(TI)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
    .ser_clk(sclk), .ser_din(sdi), .ser_latch(slat), .ser_dout(sdo)
  );

  int total = 0, bad = 0, cyc = 0, settle = 0;
  logic [3:0] hist [HL];
  int m_dly [NCH];
  logic [19:0] sh_model = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic chk_ena = 0;
  string tag_force = "";

  function automatic logic [3:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[3:0];
  endfunction

  // Bench-side view of the word: channel n code sits 4n bits below the top nibble.
  function automatic int dly_from_word(logic [19:0] w, int n);
    int c;
    c = int'((w >> (16 - 4 * n)) & 20'hF);
    return w[3 - n] ? (TI * c + T0) : 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] v);
    @(negedge clk);
    if (chk_ena && settle == 0) begin
      for (int n = 0; n < NCH; n++) begin
        string tg;
        logic e;
        e = (m_dly[n] == 0) ? 1'b0 : hist[(cyc - m_dly[n] - 1) & (HL - 1)][n];
        if (tag_force != "")                       tg = tag_force;
        else if (m_dly[n] == 0)                    tg = "R7";
        else if (m_dly[n] == T0 || m_dly[n] == MAXD) tg = "R10";
        else                                       tg = "R2 R4 R9";
        check(tg, 32'(dout[n]), 32'(e));
      end
    end else if (settle > 0) settle--;
    din = v;
    hist[cyc & (HL - 1)] = v;
    cyc++;
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; sclk = 0;
    repeat (3) step(rnd());
    sclk = 1;
    sh_model = {sh_model[18:0], b};
    repeat (3) step(rnd());
  endtask

  task automatic set_model(input logic [19:0] w);
    for (int n = 0; n < NCH; n++) m_dly[n] = dly_from_word(w, n);
    settle = MAXD + 6;
  endtask

  task automatic latch_pulse();
    sclk = 0;
    slat = 1;
    set_model(sh_model);
    repeat (4) step(rnd());
    slat = 0;
    repeat (4) step(rnd());
  endtask

  task automatic shift_word(input logic [19:0] w, input int nbits);
    for (int b = 19; b > 19 - nbits; b--) shift_bit(w[b]);
    sclk = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < NCH; n++) m_dly[n] = 0;
    for (int i = 0; i < HL; i++) hist[i] = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1", 32'(dout), 0);
    check("R1", 32'(sdo), 0);
    rst_n = 1;
    repeat (4) step(rnd());
    // R1: after release, nothing latched yet
    check("R1", 32'(dout), 0);
    check("R1", 32'(sdo), 0);
    chk_ena = 1;
    repeat (10) step(rnd());

    // R5: word reappears on the serial output over the next 20 shifts
    shift_word(20'hA5C39, 20);
    for (int k = 0; k < WW; k++) begin
      logic [19:0] w;
      w = 20'hA5C39;
      check("R5", 32'(sdo), 32'(w[19 - k]));
      shift_bit(1'b0);
    end
    sclk = 0;
    repeat (4) step(rnd());
    check("R5", 32'(sdo), 0);
    check("R6", 32'(dout), 0);

    // Vector walk: shift under the old setting (R6), latch, then run
    for (int v = 0; v < 5; v++) begin
      tag_force = "R6";
      shift_word(VEC[v].word, 20);
      tag_force = "";
      // table latencies against the bench decode of the word
      check("R4", 32'(dly_from_word(VEC[v].word, 0)), 32'(VEC[v].d0));
      check("R4", 32'(dly_from_word(VEC[v].word, 3)), 32'(VEC[v].d3));
      latch_pulse();
      m_dly[0] = VEC[v].d0; m_dly[1] = VEC[v].d1;
      m_dly[2] = VEC[v].d2; m_dly[3] = VEC[v].d3;
      repeat (MAXD + 40) step(rnd());
    end

    // R3: single pulse of width 2 on channel 0 (latency 3 after last vector)
    begin
      int hi_in, hi_out;
      hi_in = 0; hi_out = 0;
      repeat (MAXD + 4) step(4'h0);
      step(4'h1); step(4'h1);
      for (int i = 0; i < 20; i++) begin
        step(4'h0);
        if (dout[0]) hi_out++;
      end
      hi_in = 2;
      check("R3", 32'(hi_out), 32'(hi_in));
    end

    // R8: shift and strobe edges in the same cycle
    shift_word(20'h3C82F, 20);
    latch_pulse();
    repeat (MAXD + 20) step(rnd());
    shift_word(20'h6B2D4, 19);
    sdi = 1'b0;
    repeat (3) step(rnd());
    sclk = 1; slat = 1;
    set_model(sh_model);            // content before the final shift
    check("R8", 32'(sh_model), 32'({1'b1, 19'(20'h6B2D4 >> 1)}));
    sh_model = {sh_model[18:0], 1'b0};
    repeat (4) step(rnd());
    sclk = 0; slat = 0;
    tag_force = "R8";
    repeat (MAXD + 40) step(rnd());
    tag_force = "";

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule